// File: doc/BRIEF.md
# Staircase ADC Conversion Sequencer

This block is the digital half of a counting (staircase) analog-to-digital converter. An external DAC is driven from the block's code output, and an external comparator reports back a single bit that goes high once the DAC voltage has reached the analog input. When a start-of-conversion pulse arrives while the block is idle, it clears its counter to zero and then steps the code up by one on every clock. The comparator bit acts as an active-high inhibit: the first clock edge on which it is high freezes the counter, copies the code into a result register and raises an end-of-conversion flag for one cycle.

If the comparator never trips, the count stops at the all-ones code and that value is latched. Each accepted start pulse therefore produces exactly one result. With a 4-bit code the longest conversion takes 16 clock periods from the start edge. Zero is a valid result, because the comparator is examined while the counter still holds zero. Start pulses that arrive during a conversion are ignored. The result holds until the next conversion latches a new value.

Top module: `staircase_adc_ctrl`

## Requirements
- R1: While reset is active and after it is released, dac_code_o, result_o and eoc_o are all zero and the block is idle.
- R2: A start_i pulse sampled high while idle clears the counter: dac_code_o reads 0 after that edge and a conversion is busy.
- R3: While busy with cmp_i low and the code below all-ones, dac_code_o increases by exactly one per clock.
- R4: While busy, the first edge with cmp_i high (high means stop) freezes dac_code_o, copies it to result_o and sets eoc_o; with a comparator that trips at code k, eoc_o is visible k+1 clocks after the start edge.
- R5: Code 0 is a reachable result: if cmp_i is already high on the first busy cycle, result_o becomes 0.
- R6: If cmp_i never goes high, counting stops at all-ones (15 for 4 bits), that value is latched and eoc_o rises 16 clocks after the start edge.
- R7: eoc_o is high for exactly one clock per conversion.
- R8: start_i pulses sampled while busy, including on the latching edge, neither restart nor extend the conversion.
- R9: result_o changes only on the edge that raises eoc_o, and dac_code_o holds its last value while idle.
- R10: cmp_i has no effect while idle: no eoc_o, no change to result_o or dac_code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start-of-conversion pulse |
| cmp_i | input | 1 | Comparator inhibit, high when the DAC level has reached the input |
| dac_code_o | output | CODE_W | Code driven to the external DAC |
| result_o | output | CODE_W | Latched conversion result |
| eoc_o | output | 1 | End of conversion, one clock wide |

## Verification
Two functions can fall on the same clock edge. In the first case, the comparator trips while a new start pulse is present: the bench raises start on the cycle in which the latch happens and expects that pulse to be dropped. It then checks that the counter stays frozen and that no second end-of-conversion follows. In the second case, a start pulse coincides with the cycle in which end-of-conversion is showing; conversions are issued back to back to provoke this, and the new conversion must begin at zero while the previous result stays valid until the next latch.

// File: rtl/adc_ctrl_pkg.sv
// Shared types for the staircase conversion sequencer.
package adc_ctrl_pkg;
    // Sequencer state: waiting for a start pulse, or stepping the code.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_t;
endpackage

// File: rtl/count_unit.sv
// Up-counter that drives the DAC code.
// Assumes: clr_i and en_i are never high together (the sequencer guarantees this).
// The counter saturates by policy: the sequencer stops enabling it at all-ones.
module count_unit #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [CODE_W-1:0] cnt_o,
    output logic              at_max_o
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    // Clear on start, step by one when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= '0;
        else if (en_i)
            cnt_o <= cnt_o + 1'b1;
    end

    // Flag the final code so the sequencer can stop without wrapping.
    always_comb at_max_o = (cnt_o == MAX_CODE);
endmodule

// File: rtl/seq_ctrl.sv
// Two-state sequencer. It accepts start only when idle, runs until the
// comparator inhibit or the final code, then requests a latch and returns idle.
// Assumes: cmp_i is already synchronous to clk.
module seq_ctrl
    import adc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cmp_i,
    input  logic at_max_i,
    output logic clr_o,
    output logic en_o,
    output logic latch_o,
    output logic busy_o
);
    conv_state_t state_q;

    // Decode control strobes from the current state and inputs.
    always_comb begin
        busy_o  = (state_q == ST_RUN);
        clr_o   = !busy_o && start_i;
        latch_o = busy_o && (cmp_i || at_max_i);
        en_o    = busy_o && !latch_o;
    end

    // Advance the state: idle to run on start, run to idle on latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (clr_o)
            state_q <= ST_RUN;
        else if (latch_o)
            state_q <= ST_IDLE;
    end
endmodule

// File: rtl/result_reg.sv
// Result holding register and one-cycle end-of-conversion flag.
// Assumes: latch_i is a single-cycle strobe from the sequencer.
module result_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] result_o,
    output logic              eoc_o
);
    // Capture the frozen code on the latch strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_o <= '0;
        else if (latch_i)
            result_o <= code_i;
    end

    // Raise the end-of-conversion flag for the cycle after the latch edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eoc_o <= 1'b0;
        else
            eoc_o <= latch_i;
    end
endmodule

// File: rtl/staircase_adc_ctrl.sv
// Top of the staircase ADC sequencer: counter, sequencer and result register.
// Assumes: an external DAC converts dac_code_o and an external comparator
// drives cmp_i high once that level has reached the analog input.
module staircase_adc_ctrl #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              eoc_o,
    output logic [CODE_W-1:0] result_o
);
    logic clr;
    logic en;
    logic latch;
    logic busy;
    logic at_max;

    count_unit #(.CODE_W(CODE_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .en_i     (en),
        .cnt_o    (dac_code_o),
        .at_max_o (at_max)
    );

    seq_ctrl u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_i    (cmp_i),
        .at_max_i (at_max),
        .clr_o    (clr),
        .en_o     (en),
        .latch_o  (latch),
        .busy_o   (busy)
    );

    result_reg #(.CODE_W(CODE_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_i  (latch),
        .code_i   (dac_code_o),
        .result_o (result_o),
        .eoc_o    (eoc_o)
    );
endmodule

// File: rtl/staircase_adc_ctrl_chk.sv
// Checker for the staircase sequencer, bound to the top module.
// Observes the ports plus the internal busy state.
module staircase_adc_ctrl_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cmp_i,
    input logic              busy,
    input logic [CODE_W-1:0] dac_code_o,
    input logic [CODE_W-1:0] result_o,
    input logic              eoc_o
);
    localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

    // R2: an idle start clears the counter and begins a conversion.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i) |=> (busy && dac_code_o == '0));

    // R3 and R8: a busy step advances by one even if start is high.
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_i && dac_code_o != MAX_CODE)
        |=> (busy && dac_code_o == CODE_W'($past(dac_code_o) + 1'b1)));

    // R4: a comparator trip freezes and latches the current code.
    a_r4_latch_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp_i) |=> (eoc_o && !busy && result_o == $past(dac_code_o)
                             && $stable(dac_code_o)));

    // R6: the final code ends the conversion without wrapping.
    a_r6_stop_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dac_code_o == MAX_CODE)
        |=> (eoc_o && !busy && result_o == MAX_CODE && dac_code_o == MAX_CODE));

    // R7: the end-of-conversion flag is one clock wide.
    a_r7_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> !eoc_o);

    // R9: the result moves only together with the end-of-conversion flag.
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> $stable(result_o));

    // R10: idle with no start leaves the code frozen and raises no flag.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> (!eoc_o && $stable(dac_code_o)));
endmodule

bind staircase_adc_ctrl staircase_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_i      (cmp_i),
    .busy       (busy),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .eoc_o      (eoc_o)
);

// File: tb/staircase_adc_ctrl_tb.sv
// Self-checking bench: the comparator is modelled as code >= input level.
module staircase_adc_ctrl_tb;
    localparam int CODE_W = 4;
    localparam int MAXV   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              cmp_force = 1'b0;
    logic [CODE_W:0]   ain_lvl = '1;
    logic              cmp_i;
    logic [CODE_W-1:0] dac_code_o;
    logic [CODE_W-1:0] result_o;
    logic              eoc_o;

    int checks = 0;
    int errors = 0;
    int seed_init;

    always #5 clk = ~clk;

    // Comparator model: trips once the DAC code reaches the input level.
    assign cmp_i = cmp_force || ({1'b0, dac_code_o} >= ain_lvl);

    staircase_adc_ctrl #(.CODE_W(CODE_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .dac_code_o (dac_code_o),
        .eoc_o      (eoc_o),
        .result_o   (result_o)
    );

    function automatic int exp_result(int lvl);
        return (lvl > MAXV) ? MAXV : lvl;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion. Start is raised at the current negedge.
    // poke: 0 none, 1 start mid-run, 2 start on the latch edge.
    // tail: idle cycles checked afterwards (0 = back-to-back).
    task automatic convert(int lvl, int poke, int tail);
        int  exp_r  = exp_result(lvl);
        int  cyc    = 0;
        bit  step_ok = 1'b1;
        int  prev_res = result_o;
        ain_lvl = (CODE_W+1)'(lvl);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        check(dac_code_o == 0, "R2", dac_code_o, 0);
        check(result_o == prev_res[CODE_W-1:0], "R9", result_o, prev_res);
        while (!eoc_o && cyc < 40) begin
            if (dac_code_o != CODE_W'(cyc - 1)) step_ok = 1'b0;
            if (poke == 1 && cyc == 2 && exp_r >= 2) start_i = 1'b1;
            if (poke == 2 && cyc == exp_r + 1) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(step_ok, "R3", step_ok, 1);
        check(eoc_o == 1'b1, "R4", eoc_o, 1);
        if (exp_r == 0)
            check(result_o == 0, "R5", result_o, 0);
        else if (lvl > MAXV)
            check(result_o == MAXV, "R6", result_o, MAXV);
        else
            check(result_o == exp_r, "R4", result_o, exp_r);
        if (poke != 0)
            check(cyc == exp_r + 2, "R8 latency", cyc, exp_r + 2);
        else
            check(cyc == exp_r + 2, "R4 latency", cyc, exp_r + 2);
        if (tail > 0) begin
            bit quiet = 1'b1;
            for (int i = 0; i < tail; i++) begin
                @(negedge clk);
                if (eoc_o || dac_code_o != exp_r || result_o != exp_r) quiet = 1'b0;
            end
            check(quiet, "R7", quiet, 1);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'd20240611);
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(dac_code_o == 0, "R1", dac_code_o, 0);
        check(result_o == 0, "R1", result_o, 0);
        check(eoc_o == 0, "R1", eoc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code_o == 0 && eoc_o == 0, "R1", eoc_o, 0);

        // R10: comparator high while idle has no effect.
        cmp_force = 1'b1;
        begin
            bit quiet = 1'b1;
            repeat (5) begin
                @(negedge clk);
                if (eoc_o || dac_code_o != 0 || result_o != 0) quiet = 1'b0;
            end
            check(quiet, "R10", quiet, 1);
        end
        cmp_force = 1'b0;

        // Directed corners.
        convert(0, 0, 3);              // R5 zero result
        convert(16, 0, 3);             // R6 never trips
        convert(15, 0, 3);             // trips exactly at top code
        convert(7, 1, 3);              // R8 start mid-run
        convert(9, 2, 4);              // R8 start on latch edge
        convert(3, 0, 0);              // back-to-back: start on eoc cycle
        convert(12, 0, 0);
        convert(0, 2, 3);              // latch on first cycle with start

        // Random conversions.
        for (int n = 0; n < 60; n++) begin
            convert(int'($urandom_range(0, 16)), int'($urandom_range(0, 2)),
                    int'($urandom_range(0, 3)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule